// File: doc/BRIEF.md
# Two-Cycle Sine/Cosine Oscillator

This block is a numerically controlled oscillator that produces a quadrature pair: a signed 16-bit sine and a signed 16-bit cosine of a running 32-bit phase. Each sample's phase is the current accumulator value plus an optional phase offset word. The accumulator then advances by the tuning word plus an optional frequency offset word, and it wraps modulo 2^32. The upper 16 bits of the sample phase pick the angle. The top 8 of those bits index a coarse table that covers the whole circle. The next 8 bits index a fine table of small angles. The two are combined through the angle-sum identities.

To save multipliers, the identity products go through a single pair of multipliers over two clock cycles. The first cycle forms the products that use the fine cosine. The second cycle forms the products that use the fine sine and adds or subtracts them. The block therefore takes a new phase on the first cycle of every two-cycle pair and emits one sample pair every two clocks. A one-cycle valid pulse marks each new sample pair. While the clock enable is low the whole pipeline stands still.

Top module: `nco2_sincos`

## Requirements
- R1: While `rst` is high, and on the cycle after it is released, `sin_o` and `cos_o` are 0 and `valid_o` is low.
- R2: The first sample after reset has phase 0 (accumulator 0, no offset) and reads exactly `sin_o` = 0 and `cos_o` = 32767.
- R3: `valid_o` is high for exactly one clock per enabled two-cycle pair. It is never high on two clocks in a row. A sample whose inputs are taken at rising edge n is registered at rising edge n+4.
- R4: Each sample is within 3 LSB of round(32767·sin θ) and round(32767·cos θ), where θ = 2π·P/65536 and P is bits [31:16] of the sample phase. Results are rounded and clamped to the signed 16-bit range.
- R5: A tuning word of 85899346 repeats the waveform every 50 samples. Sample 50 equals sample 0 exactly.
- R6: The phase accumulator wraps modulo 2^32, so large tuning words keep tracking the modular phase.
- R7: The inputs are taken only on the first enabled edge of each pair. The first pair starts at the first enabled edge after reset. Values present on the second edge of a pair have no effect on any output.
- R8: `phase_mod` is added to the phase of the sample it accompanies only. It does not change the accumulator.
- R9: `freq_mod` is added to `phase_inc` for the accumulator step that follows that sample, so its effect persists in every later phase.
- R10: While `en` is low, `valid_o` stays low and `sin_o`/`cos_o` hold. When `en` returns, the sample sequence continues exactly as if there had been no pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable; the pipeline advances only when high |
| phase_inc | input | 32 | Tuning word added to the phase accumulator each pair |
| phase_mod | input | 32 | Phase offset for the sample taken this pair |
| freq_mod | input | 32 | Offset added to the tuning word this pair |
| sin_o | output | 16 | Signed sine sample |
| cos_o | output | 16 | Signed cosine sample |
| valid_o | output | 1 | One-clock pulse marking a new sample pair |

## Verification
The bench attacks the two-cycle cadence directly. It drives deliberately wrong tuning and offset words on the second edge of each pair. A design that sampled on the wrong edge, or on both edges, would drift from the predicted phases at once. It also pauses the enable for one cycle and for several cycles, in the middle of the pipeline. A design that let part of the pipeline run, or pulsed valid while idle, would lose or duplicate a sample, or change the held outputs. Phase offsets are mixed in and then removed, to catch an offset that leaks into the accumulator. Frequency offsets alternate sign, to catch one that is applied only once. Zero phase, the half-period point and the 50-sample repeat are compared exactly, which exposes a swapped product pair, a wrong subtraction sign or an off-by-one table index.

// File: rtl/nco2_pkg.sv
package nco2_pkg;

  // Which half of the two-cycle multiply schedule is active.
  typedef enum logic {
    SLOT_A = 1'b0,  // take inputs, form the fine-cosine products
    SLOT_B = 1'b1   // form the fine-sine products and combine
  } slot_e;

  localparam int DEF_PHASE_W  = 32;
  localparam int DEF_OUT_W    = 16;
  localparam int DEF_COARSE_W = 8;
  localparam int DEF_FINE_W   = 8;
  localparam int DEF_FINE_DW  = 18;

endpackage

// File: rtl/nco2_phase_acc.sv
module nco2_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 16,
  parameter bit MOD_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [PHASE_W-1:0] inc,
  input  logic [PHASE_W-1:0] pmod,
  input  logic [PHASE_W-1:0] fmod,
  output logic [IDX_W-1:0]   idx_q,
  output logic [PHASE_W-1:0] acc_q
);

  localparam int LOW_W = PHASE_W - IDX_W;

  logic [PHASE_W-1:0] pm_eff;
  logic [PHASE_W-1:0] fm_eff;
  logic [PHASE_W-1:0] ph_now;
  logic               unused_low;

  generate
    if (MOD_EN) begin : g_mod
      assign pm_eff = pmod;
      assign fm_eff = fmod;
    end else begin : g_nomod
      logic unused_mod;
      assign pm_eff     = '0;
      assign fm_eff     = '0;
      assign unused_mod = ^{pmod, fmod};
    end
  endgenerate

  assign ph_now     = acc_q + pm_eff;
  assign unused_low = ^ph_now[LOW_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      idx_q <= ph_now[PHASE_W-1 -: IDX_W];
      acc_q <= acc_q + inc + fm_eff;
    end
  end

endmodule

// File: rtl/nco2_trig_rom.sv
module nco2_trig_rom #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int AMP        = 32767,
  parameter int ANGLE_BITS = 8
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [DATA_W-1:0] sin_q,
  output logic signed [DATA_W-1:0] cos_q
);

  localparam int  DEPTH  = 1 << ADDR_W;
  localparam real TWO_PI = 6.283185307179586;
  localparam real STEP   = TWO_PI / (2.0 ** ANGLE_BITS);

  logic signed [DATA_W-1:0] sin_mem [DEPTH];
  logic signed [DATA_W-1:0] cos_mem [DEPTH];

  // Table contents are computed at elaboration; read-only afterwards.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      sin_mem[i] = DATA_W'(int'(real'(AMP) * $sin(STEP * real'(i))));
      cos_mem[i] = DATA_W'(int'(real'(AMP) * $cos(STEP * real'(i))));
    end
  end

  // Registered read with enable, so the tables map onto block RAM.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      sin_q <= sin_mem[addr];
      cos_q <= cos_mem[addr];
    end
  end

endmodule

// File: rtl/nco2_mac.sv
module nco2_mac
  import nco2_pkg::*;
#(
  parameter int A_W = 16,
  parameter int B_W = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  slot_e                   slot,
  input  logic signed [A_W-1:0]   a_sin,
  input  logic signed [A_W-1:0]   a_cos,
  input  logic signed [B_W-1:0]   b_sin,
  input  logic signed [B_W-1:0]   b_cos,
  output logic signed [A_W+B_W:0] sum_sin,
  output logic signed [A_W+B_W:0] sum_cos
);

  localparam int PROD_W = A_W + B_W;

  logic signed [A_W-1:0]    x1, x2;
  logic signed [B_W-1:0]    y1, y2;
  logic signed [PROD_W-1:0] p1, p2;
  logic signed [PROD_W:0]   e1, e2;

  // Operand steering for the shared multiplier pair.
  always_comb begin
    if (slot == SLOT_A) begin
      x1 = a_sin;  y1 = b_cos;
      x2 = a_cos;  y2 = b_cos;
    end else begin
      x1 = a_cos;  y1 = b_sin;
      x2 = a_sin;  y2 = b_sin;
    end
  end

  assign p1 = x1 * y1;
  assign p2 = x2 * y2;
  assign e1 = {p1[PROD_W-1], p1};
  assign e2 = {p2[PROD_W-1], p2};

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_sin <= '0;
      sum_cos <= '0;
    end else if (en) begin
      if (slot == SLOT_A) begin
        sum_sin <= e1;
        sum_cos <= e2;
      end else begin
        sum_sin <= sum_sin + e1;
        sum_cos <= sum_cos - e2;
      end
    end
  end

endmodule

// File: rtl/nco2_sincos.sv
module nco2_sincos
  import nco2_pkg::*;
#(
  parameter int PHASE_W     = DEF_PHASE_W,
  parameter int OUT_W       = DEF_OUT_W,
  parameter int COARSE_BITS = DEF_COARSE_W,
  parameter int FINE_BITS   = DEF_FINE_W,
  parameter int FINE_DW     = DEF_FINE_DW,
  parameter bit MOD_EN      = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [PHASE_W-1:0]      phase_inc,
  input  logic [PHASE_W-1:0]      phase_mod,
  input  logic [PHASE_W-1:0]      freq_mod,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o,
  output logic                    valid_o
);

  localparam int IDX_W      = COARSE_BITS + FINE_BITS;
  localparam int ACC_W      = OUT_W + FINE_DW + 1;
  localparam int SHIFT      = FINE_DW - 2;
  localparam int COARSE_AMP = (1 << (OUT_W - 1)) - 1;
  localparam int FINE_AMP   = 1 << SHIFT;
  localparam int FILL_FULL  = 2;  // samples ahead of the output stage
  localparam int FILL_W     = $clog2(FILL_FULL + 1);

  localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) << (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'(COARSE_AMP);
  localparam logic signed [ACC_W-1:0] NEG_LIM = ~POS_LIM;

  slot_e                    slot_q;
  logic [FILL_W-1:0]        fill_q;
  logic                     sample_go, rom_go, out_go;
  logic [IDX_W-1:0]         idx_q;
  logic [PHASE_W-1:0]       acc_q;
  logic signed [OUT_W-1:0]  c_sin, c_cos;
  logic signed [FINE_DW-1:0] f_sin, f_cos;
  logic signed [ACC_W-1:0]  sum_sin, sum_cos;
  logic signed [ACC_W-1:0]  sh_sin, sh_cos;

  // Two-cycle sequencer and pipeline-fill tracking.
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SLOT_A;
      fill_q <= '0;
    end else if (en) begin
      slot_q <= (slot_q == SLOT_A) ? SLOT_B : SLOT_A;
      if (slot_q == SLOT_A && fill_q != FILL_W'(FILL_FULL))
        fill_q <= fill_q + 1'b1;
    end
  end

  assign sample_go = en && (slot_q == SLOT_A);
  assign rom_go    = en && (slot_q == SLOT_B);
  assign out_go    = sample_go && (fill_q == FILL_W'(FILL_FULL));

  nco2_phase_acc #(
    .PHASE_W (PHASE_W),
    .IDX_W   (IDX_W),
    .MOD_EN  (MOD_EN)
  ) u_phase (
    .clk   (clk),
    .rst   (rst),
    .load  (sample_go),
    .inc   (phase_inc),
    .pmod  (phase_mod),
    .fmod  (freq_mod),
    .idx_q (idx_q),
    .acc_q (acc_q)
  );

  nco2_trig_rom #(
    .ADDR_W     (COARSE_BITS),
    .DATA_W     (OUT_W),
    .AMP        (COARSE_AMP),
    .ANGLE_BITS (COARSE_BITS)
  ) u_coarse (
    .clk   (clk),
    .rd_en (rom_go),
    .addr  (idx_q[IDX_W-1 -: COARSE_BITS]),
    .sin_q (c_sin),
    .cos_q (c_cos)
  );

  nco2_trig_rom #(
    .ADDR_W     (FINE_BITS),
    .DATA_W     (FINE_DW),
    .AMP        (FINE_AMP),
    .ANGLE_BITS (IDX_W)
  ) u_fine (
    .clk   (clk),
    .rd_en (rom_go),
    .addr  (idx_q[FINE_BITS-1:0]),
    .sin_q (f_sin),
    .cos_q (f_cos)
  );

  nco2_mac #(
    .A_W (OUT_W),
    .B_W (FINE_DW)
  ) u_mac (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .slot    (slot_q),
    .a_sin   (c_sin),
    .a_cos   (c_cos),
    .b_sin   (f_sin),
    .b_cos   (f_cos),
    .sum_sin (sum_sin),
    .sum_cos (sum_cos)
  );

  function automatic logic signed [OUT_W-1:0] clip(input logic signed [ACC_W-1:0] v);
    if (v > POS_LIM)      clip = POS_LIM[OUT_W-1:0];
    else if (v < NEG_LIM) clip = NEG_LIM[OUT_W-1:0];
    else                  clip = v[OUT_W-1:0];
  endfunction

  assign sh_sin = (sum_sin + HALF) >>> SHIFT;
  assign sh_cos = (sum_cos + HALF) >>> SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_o   <= '0;
      cos_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= out_go;
      if (out_go) begin
        sin_o <= clip(sh_sin);
        cos_o <= clip(sh_cos);
      end
    end
  end

  // R3: a valid pulse lasts exactly one clock.
  assert_valid_gap_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R3: a valid pulse always follows an enabled edge.
  assert_valid_needs_en_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(en));

  // R3: with enable held, pulses recur every second clock.
  assert_valid_cadence_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && en) ##1 en |=> valid_o);

  // R7: the accumulator does not move on the second edge of a pair.
  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (en && slot_q == SLOT_B) |=> $stable(acc_q));

  // R10: with enable low, outputs hold and no pulse appears.
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!valid_o && $stable(sin_o) && $stable(cos_o)));

endmodule

// File: tb/nco2_sincos_tb_top.sv
`timescale 1ns/1ps
module nco2_sincos_tb_top;

  logic               clk = 1'b0;
  logic               rst;
  logic               en;
  logic [31:0]        phase_inc, phase_mod, freq_mod;
  logic signed [15:0] sin_o, cos_o;
  logic               valid_o;

  always #2.5 clk = ~clk;  // 200 MHz

  nco2_sincos dut_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .phase_inc (phase_inc),
    .phase_mod (phase_mod),
    .freq_mod  (freq_mod),
    .sin_o     (sin_o),
    .cos_o     (cos_o),
    .valid_o   (valid_o)
  );

  typedef struct {
    int    es;
    int    ec;
    int    tol;
    int    lat;
    string req;
  } item_t;

  item_t       exp_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  bit          done = 1'b0;
  bit          prev_valid = 1'b0;
  logic [31:0] macc;
  int          cap_sin [0:127];
  int          cap_cos [0:127];
  int          cap_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int expv, input int tol);
    n_chk++;
    if (act - expv > tol || expv - act > tol) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Ideal model from R4: angle from bits [31:16] of the phase, amplitude 32767.
  function automatic int ideal(input bit want_sin, input logic [31:0] ph);
    real a;
    a = 6.283185307179586 * real'(ph[31:16]) / 65536.0;
    return want_sin ? int'(32767.0 * $sin(a)) : int'(32767.0 * $cos(a));
  endfunction

  // Monitor: pops one prediction per valid pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) begin
        check("R3 no back-to-back valid", int'(prev_valid), 0, 0);
        if (exp_q.size() == 0) begin
          check("R3 unexpected valid pulse", 1, 0, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check({it.req, " sin"}, int'(sin_o), it.es, it.tol);
          check({it.req, " cos"}, int'(cos_o), it.ec, it.tol);
          if (it.lat >= 0) check("R3 latency", cyc - it.lat, 4, 0);
          if (cap_n < 128) begin
            cap_sin[cap_n] = int'(sin_o);
            cap_cos[cap_n] = int'(cos_o);
          end
          cap_n++;
        end
      end
      prev_valid = valid_o;
    end
  end

  // Driver: one sample per call, two enabled edges.
  task automatic issue(input logic [31:0] i, input logic [31:0] p, input logic [31:0] f,
                       input bit junk, input int tol, input bit lat, input string req);
    item_t       it;
    logic [31:0] ph;
    ph     = macc + p;
    macc   = macc + i + f;
    it.es  = ideal(1'b1, ph);
    it.ec  = ideal(1'b0, ph);
    it.tol = tol;
    it.lat = lat ? cyc + 1 : -1;
    it.req = req;
    exp_q.push_back(it);
    phase_inc = i; phase_mod = p; freq_mod = f; en = 1'b1;
    @(posedge clk); @(negedge clk);
    if (junk) begin  // R7: second-edge values must be ignored
      phase_inc = ~i;
      phase_mod = 32'h5A5A_0000;
      freq_mod  = 32'h1357_9BDF;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0;
    phase_inc = '0; phase_mod = '0; freq_mod = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 sin in reset", int'(sin_o), 0, 0);
    check("R1 cos in reset", int'(cos_o), 0, 0);
    check("R1 valid in reset", int'(valid_o), 0, 0);
    rst = 1'b0;
    macc = '0;
    cap_n = 0;
    prev_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1 valid after release", int'(valid_o), 0, 0);
    check("R1 sin after release", int'(sin_o), 0, 0);
  endtask

  task automatic flush();
    en = 1'b1; phase_inc = '0; phase_mod = '0; freq_mod = '0;
    repeat (4) begin @(posedge clk); @(negedge clk); end
    en = 1'b0;
    check("R3 every sample delivered", exp_q.size(), 0, 0);
  endtask

  task automatic pause(input int n);
    int s, c;
    s = int'(sin_o); c = int'(cos_o);
    en = 1'b0;
    phase_inc = 32'hFFFF_0000;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      check("R10 no valid while idle", int'(valid_o), 0, 0);
      check("R10 sin holds", int'(sin_o), s, 0);
      check("R10 cos holds", int'(cos_o), c, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; macc = '0;
    phase_inc = '0; phase_mod = '0; freq_mod = '0;

    // R2, R4, R5: 50-sample period
    do_reset();
    issue(32'd85899346, 0, 0, 1'b0, 0, 1'b1, "R2 zero phase");
    for (int k = 1; k < 60; k++) issue(32'd85899346, 0, 0, 1'b0, 3, 1'b0, "R4 accuracy");
    flush();
    check("R5 sample 50 sin equals sample 0", cap_sin[50], cap_sin[0], 0);
    check("R5 sample 50 cos equals sample 0", cap_cos[50], cap_cos[0], 0);
    check("R5 half period cos", cap_cos[25], -32767, 0);

    // R6: large tuning word, frequent wrap
    do_reset();
    for (int k = 0; k < 40; k++) issue(32'h9E37_79B9, 0, 0, 1'b0, 3, 1'b0, "R6 wrap");
    flush();

    // R7: junk on the second edge, varying tuning word
    do_reset();
    for (int k = 0; k < 30; k++)
      issue(32'h0800_0000 + 32'(k) * 32'h0011_0000, 0, 0, 1'b1, 3, 1'b0, "R7 second edge ignored");
    flush();

    // R8: per-sample phase offsets
    do_reset();
    for (int k = 0; k < 30; k++)
      issue(32'h0200_0000, (k % 3 == 1) ? 32'h4000_0000 : (k % 3 == 2) ? 32'hC123_0000 : 32'h0,
            0, 1'b0, 3, 1'b0, "R8 phase offset");
    flush();

    // R9: frequency offsets of both signs
    do_reset();
    for (int k = 0; k < 30; k++)
      issue(32'h0100_0000, 0, (k % 2 == 1) ? 32'h0300_0000 : 32'hFF80_0000,
            1'b0, 3, 1'b0, "R9 frequency offset");
    flush();

    // R10: pauses in mid-stream
    do_reset();
    for (int k = 0; k < 10; k++) issue(32'h0345_6789, 0, 0, 1'b0, 3, 1'b0, "R10 before pause");
    pause(5);
    for (int k = 0; k < 10; k++) issue(32'h0345_6789, 0, 0, 1'b0, 3, 1'b0, "R10 after long pause");
    pause(1);
    for (int k = 0; k < 10; k++) issue(32'h0345_6789, 0, 0, 1'b1, 3, 1'b0, "R10 after short pause");
    flush();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule